// File: doc/BRIEF.md
# Three-wire serial register slave

This block is the device side of a three-line serial control bus made of a data line, a bit clock and a frame strobe. It sits in a device that runs on a local reference clock. All three lines are treated as asynchronous. Each line passes through a two-flop synchronizer. Edges are found by comparing two consecutive synchronized samples. No line activity is seen while the reference clock is stopped.

A frame starts when the frame strobe falls. It carries an 8-bit address and then a 24-bit data word. Each bit is taken on a rising edge of the bit clock, least significant bit first. The low address nibble arrives with the strobe low. The high nibble and all data bits arrive with the strobe high. A write takes effect only at the falling strobe edge that closes the frame. Two 24-bit control registers can be written.

A third address selects a read. At the ninth falling edge of the bit clock, the block copies a 24-bit parallel input into an output shift register. It starts driving the data line and moves out one bit on each later falling edge. The master samples each bit after its next rising edge.

Top module: `tws_slave`

## Requirements
- R1: After reset, both control registers hold zero, the drive enable is low and the data output is high.
- R2: A falling edge of the frame strobe clears the bit count. Bits are taken on rising bit-clock edges, least significant bit first: 8 address bits, then 24 data bits.
- R3: A frame of exactly 32 bits to address 0xA5 loads its data word into control register 0. To address 0x5A it loads control register 1. The register changes only when the closing strobe falls, not when the last bit arrives.
- R4: A frame that is closed after fewer than 32 bits changes no register.
- R5: A frame with more than 32 bits changes no register.
- R6: Bits 0 to 3 must arrive with the strobe low, and bits 4 to 31 with the strobe high. A frame that breaks this rule changes no register.
- R7: A frame to any address other than 0xA5, 0x5A or 0xC3 changes no register and never raises the drive enable.
- R8: For address 0xC3, the parallel read input is captured at the ninth falling bit-clock edge. The drive enable rises and bit 0 appears on the data output. Each later falling edge presents the next bit. Changes to the read input after the capture do not reach the line.
- R9: The drive enable falls at the next strobe falling edge. A frame to 0xC3 changes no control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_data_i | input | 1 | Serial data line from the master (asynchronous) |
| line_clk_i | input | 1 | Serial bit clock (asynchronous) |
| line_frame_i | input | 1 | Frame strobe (asynchronous) |
| rd_value_i | input | 24 | Parallel value returned by a read |
| ctrl0_o | output | 24 | Control register 0 |
| ctrl1_o | output | 24 | Control register 1 |
| line_data_o | output | 1 | Serial data driven during a read |
| line_data_oe_o | output | 1 | Drive enable for the data line |

## Verification
A wrong bit count or a lost validity flag shows at the register ports. The symptom is either a missing update or a spurious one, and it appears a few reference cycles after the closing strobe edge. Frames are therefore replayed with short, long, misphased and foreign-address variants, and the registers are compared with a reference model after every frame. A fault in the output shifter shows within one bit-clock period on the data line or its enable. Every read bit is therefore compared with the value captured at the ninth falling edge, and the read input is changed after the capture.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int unsigned ADDR_W       = 8;
    localparam int unsigned DATA_W       = 24;
    localparam int unsigned LO_ADDR_BITS = 4;
    localparam int unsigned FRAME_BITS   = ADDR_W + DATA_W;
    localparam int unsigned CNT_W        = $clog2(FRAME_BITS + 2);
    localparam int unsigned NUM_CTRL     = 2;
    localparam int unsigned NUM_LINES    = 3;

    typedef enum int unsigned {
        LN_DATA  = 0,
        LN_CLK   = 1,
        LN_FRAME = 2
    } line_e;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int unsigned N    = 3,
    parameter logic [N-1:0] IDLE = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
        logic [N-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = line_i;
        st_d.stab = st_q.meta;
        st_d.last = st_q.stab;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{meta: IDLE, stab: IDLE, last: IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.stab;
    assign rise_o = st_q.stab & ~st_q.last;
    assign fall_o = ~st_q.stab & st_q.last;
endmodule

// File: rtl/tws_frame_rx.sv
module tws_frame_rx
    import tws_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_i,
    input  logic              frame_lvl_i,
    input  logic              clk_rise_i,
    input  logic              frame_fall_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ok_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LO   = CNT_W'(LO_ADDR_BITS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rx_t;

    rx_t rx_d, rx_q;
    logic want_low;

    always_comb begin
        rx_d     = rx_q;
        want_low = (rx_q.cnt < CNT_LO);
        if (frame_fall_i) begin
            rx_d.cnt = '0;
            rx_d.ok  = 1'b1;
        end else if (clk_rise_i) begin
            if (want_low == frame_lvl_i) begin
                rx_d.ok = 1'b0;
            end
            if (rx_q.cnt < CNT_ADDR) begin
                rx_d.addr = {bit_i, rx_q.addr[ADDR_W-1:1]};
            end else if (rx_q.cnt < CNT_FULL) begin
                rx_d.data = {bit_i, rx_q.data[DATA_W-1:1]};
            end
            if (rx_q.cnt != CNT_OVER) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign cnt_o  = rx_q.cnt;
    assign ok_o   = rx_q.ok;
    assign addr_o = rx_q.addr;
    assign data_o = rx_q.data;

    p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_fall_i |=> (cnt_o == '0));

    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_o <= CNT_OVER);
endmodule

// File: rtl/tws_read_shifter.sv
module tws_read_shifter
    import tws_pkg::*;
#(
    parameter logic [ADDR_W-1:0] READ_ADDR = 8'hC3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clk_fall_i,
    input  logic              frame_fall_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              sdo_o,
    output logic              oe_o
);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (frame_fall_i) begin
            tx_d.oe = 1'b0;
        end else if (clk_fall_i) begin
            if (cnt_i == CNT_ADDR && ok_i && addr_i == READ_ADDR) begin
                tx_d.sh = value_i;
                tx_d.oe = 1'b1;
            end else if (tx_q.oe && cnt_i > CNT_ADDR && cnt_i < CNT_FULL) begin
                tx_d.sh = {1'b1, tx_q.sh[DATA_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q <= '{sh: '1, oe: 1'b0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign oe_o  = tx_q.oe;
    assign sdo_o = tx_q.oe ? tx_q.sh[0] : 1'b1;

    p_oe_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_fall_i |=> !oe_o);

    p_drive_starts_ninth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(oe_o) |-> ($past(cnt_i) == CNT_ADDR && $past(addr_i) == READ_ADDR));
endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL0_ADDR = 8'hA5,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 8'h5A,
    parameter logic [ADDR_W-1:0] READ_ADDR  = 8'hC3,
    parameter logic [DATA_W-1:0] CTRL_RST   = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              line_data_i,
    input  logic              line_clk_i,
    input  logic              line_frame_i,
    input  logic [DATA_W-1:0] rd_value_i,
    output logic [DATA_W-1:0] ctrl0_o,
    output logic [DATA_W-1:0] ctrl1_o,
    output logic              line_data_o,
    output logic              line_data_oe_o
);
    localparam logic [NUM_CTRL-1:0][ADDR_W-1:0] CTRL_ADDRS = {CTRL1_ADDR, CTRL0_ADDR};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [NUM_LINES-1:0] raw, lvl, rise, fall;
    logic [CNT_W-1:0]     rx_cnt;
    logic                 rx_ok;
    logic [ADDR_W-1:0]    rx_addr;
    logic [DATA_W-1:0]    rx_data;

    always_comb begin
        raw           = '1;
        raw[LN_DATA]  = line_data_i;
        raw[LN_CLK]   = line_clk_i;
        raw[LN_FRAME] = line_frame_i;
    end

    tws_line_sync #(.N(NUM_LINES), .IDLE('1)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (raw),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    tws_frame_rx i_rx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bit_i        (lvl[LN_DATA]),
        .frame_lvl_i  (lvl[LN_FRAME]),
        .clk_rise_i   (rise[LN_CLK]),
        .frame_fall_i (fall[LN_FRAME]),
        .cnt_o        (rx_cnt),
        .ok_o         (rx_ok),
        .addr_o       (rx_addr),
        .data_o       (rx_data)
    );

    tws_read_shifter #(.READ_ADDR(READ_ADDR)) i_tx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clk_fall_i   (fall[LN_CLK]),
        .frame_fall_i (fall[LN_FRAME]),
        .cnt_i        (rx_cnt),
        .ok_i         (rx_ok),
        .addr_i       (rx_addr),
        .value_i      (rd_value_i),
        .sdo_o        (line_data_o),
        .oe_o         (line_data_oe_o)
    );

    typedef struct packed {
        logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  commit;

    always_comb begin
        rg_d   = rg_q;
        commit = fall[LN_FRAME] && rx_ok && (rx_cnt == CNT_FULL);
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (commit && rx_addr == CTRL_ADDRS[i]) begin
                rg_d.ctrl[i] = rx_data;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q <= '{ctrl: {NUM_CTRL{CTRL_RST}}};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ctrl0_o = rg_q.ctrl[0];
    assign ctrl1_o = rg_q.ctrl[1];

    p_commit_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(ctrl0_o) || !$stable(ctrl1_o)) |-> $past(fall[LN_FRAME]));
endmodule

// File: tb/test_tws_slave.sv
module test_tws_slave;
    localparam int HOLD = 6;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b1, lc = 1'b1, lf = 1'b1;
    logic [23:0] rdv = '0;
    logic [23:0] c0, c1;
    logic        sdo, oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit oe_seen;
    logic [23:0] e0 = '0, e1 = '0;

    always #5 clk = ~clk;

    tws_slave i_tws_slave (
        .clk_i(clk), .rst_ni(rst_n),
        .line_data_i(ld), .line_clk_i(lc), .line_frame_i(lf),
        .rd_value_i(rdv),
        .ctrl0_o(c0), .ctrl1_o(c1),
        .line_data_o(sdo), .line_data_oe_o(oe)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [23:0] data;
        logic [5:0]  nbits;
        logic        bad_phase;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 24'h123456, 6'd32, 1'b0},
        '{8'h5A, 24'hABCDEF, 6'd32, 1'b0},
        '{8'hA5, 24'h000001, 6'd31, 1'b0},
        '{8'h5A, 24'h800000, 6'd33, 1'b0},
        '{8'hA5, 24'h5A5A5A, 6'd32, 1'b1},
        '{8'h77, 24'hFFFFFF, 6'd32, 1'b0},
        '{8'h5A, 24'h000000, 6'd32, 1'b0},
        '{8'hA5, 24'hFFFFFF, 6'd32, 1'b0},
        '{8'hA5, 24'h0F0F0F, 6'd8,  1'b0},
        '{8'hC3, 24'h111111, 6'd32, 1'b0}
    };

    task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic c, input logic p);
        ld = d; lc = c; lf = p;
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        if (oe) oe_seen = 1'b1;
    endtask

    task automatic send_frame(input vec_t v);
        logic b, p;
        oe_seen = 1'b0;
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < int'(v.nbits); i++) begin
            if (i < 8)       b = v.addr[i];
            else if (i < 32) b = v.data[i-8];
            else             b = 1'b0;
            p = (i < 4) ? v.bad_phase : 1'b1;
            step(b, 1'b0, p);
            step(b, 1'b1, p);
        end
        if (v.nbits == 6'd32 && !v.bad_phase) begin
            // R3: no update before the closing strobe edge
            chk(c0 == e0 && c1 == e1, "R3 hold-before-fall", {8'h0, c0}, {8'h0, e0});
        end
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
    endtask

    task automatic read_frame(input logic [7:0] addr, input logic [23:0] val);
        rdv = val;
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            step(addr[i], 1'b0, (i < 4) ? 1'b0 : 1'b1);
            step(addr[i], 1'b1, (i < 4) ? 1'b0 : 1'b1);
        end
        chk(oe == 1'b0, "R8 no drive before ninth fall", {31'h0, oe}, 32'h0);
        for (int j = 0; j < 24; j++) begin
            step(1'b1, 1'b0, 1'b1);
            if (j == 0) begin
                chk(oe == 1'b1, "R8 drive enable at ninth fall", {31'h0, oe}, 32'h1);
                rdv = ~val;
            end
            chk(sdo == val[j], "R8 read bit", {31'h0, sdo}, {31'h0, val[j]});
            step(1'b1, 1'b1, 1'b1);
        end
        step(1'b1, 1'b1, 1'b0);
        chk(oe == 1'b0, "R9 drive released on strobe fall", {31'h0, oe}, 32'h0);
        step(1'b1, 1'b1, 1'b1);
        chk(c0 == e0 && c1 == e1, "R9 read leaves registers", {8'h0, c1}, {8'h0, e1});
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(c0 == 24'h0, "R1 ctrl0 reset", {8'h0, c0}, 32'h0);
        chk(c1 == 24'h0, "R1 ctrl1 reset", {8'h0, c1}, 32'h0);
        chk(oe == 1'b0 && sdo == 1'b1, "R1 line idle", {30'h0, oe, sdo}, 32'h1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: R2, R3, R4, R5, R6, R7
        for (int k = 0; k < NV; k++) begin
            send_frame(VECS[k]);
            if (VECS[k].nbits == 6'd32 && !VECS[k].bad_phase) begin
                if (VECS[k].addr == 8'hA5) e0 = VECS[k].data;
                else if (VECS[k].addr == 8'h5A) e1 = VECS[k].data;
            end
            chk(c0 == e0, "R2/R3/R4/R5/R6 ctrl0 after frame", {8'h0, c0}, {8'h0, e0});
            chk(c1 == e1, "R2/R3/R4/R5/R6 ctrl1 after frame", {8'h0, c1}, {8'h0, e1});
            if (VECS[k].addr != 8'hC3) begin
                chk(!oe_seen, "R7 no drive for non-read frame", {31'h0, oe_seen}, 32'h0);
            end
        end

        // R8, R9: reads with distinct patterns
        read_frame(8'hC3, 24'h5AC3F0);
        read_frame(8'hC3, 24'hA00001);

        // R7: unknown address with read-like timing gets no drive
        oe_seen = 1'b0;
        read_frame_unknown();

        // R3: write after reads still works
        send_frame('{8'h5A, 24'h0C0FFE, 6'd32, 1'b0});
        e1 = 24'h0C0FFE;
        chk(c1 == e1, "R3 ctrl1 after reads", {8'h0, c1}, {8'h0, e1});

        // R1: reset mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(c0 == 24'h0 && c1 == 24'h0, "R1 reset clears registers", {8'h0, c1}, 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic read_frame_unknown();
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            step(i[0], 1'b0, (i < 4) ? 1'b0 : 1'b1);
            step(i[0], 1'b1, (i < 4) ? 1'b0 : 1'b1);
        end
        for (int j = 0; j < 24; j++) begin
            step(1'b1, 1'b0, 1'b1);
            step(1'b1, 1'b1, 1'b1);
        end
        chk(!oe_seen, "R7 unknown address never drives", {31'h0, oe_seen}, 32'h0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk(c0 == e0 && c1 == e1, "R7 unknown address leaves registers", {8'h0, c0}, {8'h0, e0});
    endtask
endmodule